// File: doc/BRIEF.md
# Dual-Port RAM with Address-Contention Arbiter

The block is a byte-wide memory of 2048 locations with two fully independent access ports, left and right. Each port has its own active-low enable, write strobe and output enable, an 11-bit address, write data, and registered read data qualified by a valid flag. Both ports may reach any location in the same cycle. Reads have one cycle of latency. The memory always accepts an access, so there is no back-pressure. A port that does not read sees all-zero data with the valid flag low.

In master mode the block watches for both ports selecting the same location. The port that settled on that location first is granted it. The other port sees its active-low busy output go low and its writes are dropped inside the block, so that the location is never corrupted by two writers. Reads are never blocked. In slave mode, used to widen the data path next to a master, the busy outputs stay inactive and each side's busy input only gates that side's writes.

Top module: `dpr_arb_ram`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both busy outputs are high and both ports show read data 0 with valid low.
- R2: A write occurs at a clock edge where the port's enable is low and its write strobe is low. A read occurs at an edge where enable is low, write strobe is high and output enable is low. The stored byte appears on read data, with valid high, after that edge. Every address from 0x000 to 0x7FF is reachable from both ports.
- R3: With enable high, or with output enable high on a non-write access, read data becomes 0 and valid becomes low after the edge. A write strobe given with enable high leaves memory unchanged.
- R4: In master mode, a busy output goes low only after an edge where both enables were low and both addresses were equal. In every other case both busy outputs are high after the edge.
- R5: Arbitration depends only on enables and addresses. Two reads of the same location contend in the same way as a read and a write, and both reads still return data.
- R6: A port is the earlier arrival if it was already enabled at the same address in the previous cycle and the other port was not. The earlier port wins, and the later port's busy goes low after the contested edge.
- R7: If both ports arrive in the same cycle, the left port wins and the right busy goes low.
- R8: The two busy outputs are never low at the same time.
- R9: A write from a port that loses arbitration in that cycle does not change memory. A read by the winner in that cycle returns the old byte.
- R10: The winner keeps the location while the addresses stay equal and both ports stay enabled. Busy returns high after the first edge without a match.
- R11: When one port writes a location that the other port reads at the same edge, and the write is not blocked, the reader gets the newly written byte.
- R12: In slave mode both busy outputs stay high. A low busy input blocks writes from its own side only. Reads on that side and writes from the other side are unaffected.
- R13: In master mode the busy inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_en_n | input | 1 | Left port enable, active low |
| l_wr_n | input | 1 | Left write strobe, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 11 | Left address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data, zero when not valid |
| l_rvalid | output | 1 | Left read data valid |
| l_busy_n | output | 1 | Left busy flag, low means the left port lost arbitration |
| l_busy_in_n | input | 1 | Left write inhibit in slave mode, active low |
| r_en_n | input | 1 | Right port enable, active low |
| r_wr_n | input | 1 | Right write strobe, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 11 | Right address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data, zero when not valid |
| r_rvalid | output | 1 | Right read data valid |
| r_busy_n | output | 1 | Right busy flag, low means the right port lost arbitration |
| r_busy_in_n | input | 1 | Right write inhibit in slave mode, active low |

## Verification
Contention arbitration and the cross-port read bypass can act in the same cycle: one port writes a location while the other port reads it. The bench provokes this by enabling both ports on one address in the same cycle, and also by letting one port settle first so that the opposite side wins. It then judges whether the reader saw the new byte or the old one, depending on which side held the location. A master and a slave instance run the same stimulus, so the bench can also judge each side's write inhibit while the other side writes in that cycle. A behavioural model is compared with both instances on every clock.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int unsigned NPORT = 2;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  typedef struct packed {
    logic act;
    logic rd;
    logic wr;
    logic settled;
  } port_req_t;
endpackage

// File: rtl/dpr_port_dec.sv
module dpr_port_dec
  import dpr_pkg::*;
#(
  parameter int unsigned AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_n,
  input  logic          wr_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  output port_req_t     req
);
  // Previous-cycle selection, used to tell an early arrival from a late one
  logic          prev_act;
  logic [AW-1:0] prev_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_act  <= 1'b0;
      prev_addr <= '0;
    end else begin
      prev_act  <= !en_n;
      prev_addr <= addr;
    end
  end

  always_comb begin
    req.act     = !en_n;
    req.wr      = !en_n && !wr_n;
    req.rd      = !en_n && wr_n && !oe_n;
    req.settled = !en_n && prev_act && (addr == prev_addr);
  end
endmodule

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
  import dpr_pkg::*;
#(
  parameter int unsigned AW    = 11,
  parameter bit          SLAVE = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  port_req_t [NPORT-1:0]      req,
  input  logic [NPORT-1:0][AW-1:0]   addr,
  input  logic [NPORT-1:0]           ext_busy_n,
  output logic [NPORT-1:0]           inhibit,
  output logic [NPORT-1:0]           busy_n
);
  generate
    if (SLAVE) begin : g_slave
      // Busy comes from outside and only gates writes
      logic slv_unused;
      assign slv_unused = ^{clk, rst_n, req, addr};
      assign inhibit    = ~ext_busy_n;
      assign busy_n     = '1;
    end else begin : g_master
      logic   match;
      owner_e owner_q;
      owner_e owner_d;
      owner_e first;
      logic   mst_unused;

      assign mst_unused = ^{ext_busy_n, req[0].rd, req[0].wr, req[1].rd, req[1].wr};
      assign match = req[0].act && req[1].act && (addr[0] == addr[1]);
      // Right wins only when it alone was already in place; ties go left
      assign first = (req[1].settled && !req[0].settled) ? OWN_RIGHT : OWN_LEFT;

      always_comb begin
        if (!match)                  owner_d = OWN_NONE;
        else if (owner_q != OWN_NONE) owner_d = owner_q;
        else                          owner_d = first;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) owner_q <= OWN_NONE;
        else        owner_q <= owner_d;
      end

      assign inhibit[0] = match && (owner_d == OWN_RIGHT);
      assign inhibit[1] = match && (owner_d == OWN_LEFT);
      assign busy_n[0]  = (owner_q != OWN_RIGHT);
      assign busy_n[1]  = (owner_q != OWN_LEFT);
    end
  endgenerate
endmodule

// File: rtl/dpr_store.sv
module dpr_store
  import dpr_pkg::*;
#(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  port_req_t [NPORT-1:0]      req,
  input  logic [NPORT-1:0][AW-1:0]   addr,
  input  logic [NPORT-1:0][DW-1:0]   wdata,
  input  logic [NPORT-1:0]           inhibit,
  output logic [NPORT-1:0][DW-1:0]   rdata,
  output logic [NPORT-1:0]           rvalid
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [NPORT-1:0] wr_go;
  logic             st_unused;

  assign st_unused = ^{req[0].act, req[0].settled, req[1].act, req[1].settled};

  for (genvar p = 0; p < NPORT; p++) begin : g_wr
    assign wr_go[p] = req[p].wr && !inhibit[p];
  end

  // Higher index written last; only reachable with both writes unblocked
  always_ff @(posedge clk) begin
    for (int p = 0; p < NPORT; p++) begin
      if (wr_go[p]) mem[addr[p]] <= wdata[p];
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    localparam int unsigned OTH = (p == 0) ? 1 : 0;
    logic bypass;
    assign bypass = wr_go[OTH] && (addr[OTH] == addr[p]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdata[p]  <= '0;
        rvalid[p] <= 1'b0;
      end else if (req[p].rd) begin
        rdata[p]  <= bypass ? wdata[OTH] : mem[addr[p]];
        rvalid[p] <= 1'b1;
      end else begin
        rdata[p]  <= '0;
        rvalid[p] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dpr_arb_ram.sv
module dpr_arb_ram
  import dpr_pkg::*;
#(
  parameter int unsigned AW    = 11,
  parameter int unsigned DW    = 8,
  parameter bit          SLAVE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_en_n,
  input  logic          l_wr_n,
  input  logic          l_oe_n,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_rvalid,
  output logic          l_busy_n,
  input  logic          l_busy_in_n,
  input  logic          r_en_n,
  input  logic          r_wr_n,
  input  logic          r_oe_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_rvalid,
  output logic          r_busy_n,
  input  logic          r_busy_in_n
);
  logic [NPORT-1:0]         en_v, wr_v, oe_v, ext_busy_v, inhibit_v, busy_v, rvalid_v;
  logic [NPORT-1:0][AW-1:0] addr_v;
  logic [NPORT-1:0][DW-1:0] wdata_v, rdata_v;
  port_req_t [NPORT-1:0]    req_v;

  assign en_v       = {r_en_n, l_en_n};
  assign wr_v       = {r_wr_n, l_wr_n};
  assign oe_v       = {r_oe_n, l_oe_n};
  assign ext_busy_v = {r_busy_in_n, l_busy_in_n};
  assign addr_v     = {r_addr, l_addr};
  assign wdata_v    = {r_wdata, l_wdata};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpr_port_dec #(.AW(AW)) u_dec (
      .clk  (clk),
      .rst_n(rst_n),
      .en_n (en_v[p]),
      .wr_n (wr_v[p]),
      .oe_n (oe_v[p]),
      .addr (addr_v[p]),
      .req  (req_v[p])
    );
  end

  dpr_arbiter #(.AW(AW), .SLAVE(SLAVE)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req_v),
    .addr      (addr_v),
    .ext_busy_n(ext_busy_v),
    .inhibit   (inhibit_v),
    .busy_n    (busy_v)
  );

  dpr_store #(.AW(AW), .DW(DW)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req_v),
    .addr   (addr_v),
    .wdata  (wdata_v),
    .inhibit(inhibit_v),
    .rdata  (rdata_v),
    .rvalid (rvalid_v)
  );

  assign l_rdata  = rdata_v[0];
  assign r_rdata  = rdata_v[1];
  assign l_rvalid = rvalid_v[0];
  assign r_rvalid = rvalid_v[1];
  assign l_busy_n = busy_v[0];
  assign r_busy_n = busy_v[1];
endmodule

// File: rtl/dpr_arb_ram_chk.sv
module dpr_arb_ram_chk #(
  parameter int unsigned AW    = 11,
  parameter int unsigned DW    = 8,
  parameter bit          SLAVE = 1'b0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l_en_n,
  input logic          r_en_n,
  input logic [AW-1:0] l_addr,
  input logic [AW-1:0] r_addr,
  input logic          l_busy_n,
  input logic          r_busy_n,
  input logic          l_rvalid,
  input logic [DW-1:0] l_rdata
);
  logic same_loc;
  assign same_loc = !l_en_n && !r_en_n && (l_addr == r_addr);

  AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_n && !r_busy_n)); // R8

  AST_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!SLAVE && (!l_busy_n || !r_busy_n)) |-> $past(same_loc)); // R4

  AST_HOLD_LEFT_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!SLAVE && !r_busy_n && same_loc) |=> !r_busy_n); // R10

  AST_HOLD_RIGHT_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!SLAVE && !l_busy_n && same_loc) |=> !l_busy_n); // R10

  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    SLAVE |-> (l_busy_n && r_busy_n)); // R12

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(l_en_n) |-> (!l_rvalid && l_rdata == '0)); // R3
endmodule

bind dpr_arb_ram dpr_arb_ram_chk #(.AW(AW), .DW(DW), .SLAVE(SLAVE)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .l_en_n  (l_en_n),
  .r_en_n  (r_en_n),
  .l_addr  (l_addr),
  .r_addr  (r_addr),
  .l_busy_n(l_busy_n),
  .r_busy_n(r_busy_n),
  .l_rvalid(l_rvalid),
  .l_rdata (l_rdata)
);

// File: tb/dpr_arb_ram_tb.sv
module dpr_arb_ram_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        en_n [2], wr_n [2], oe_n [2], mbi [2], sbi [2];
  logic [10:0] ad [2];
  logic [7:0]  wd [2];
  logic [7:0]  mrd [2], srd [2];
  logic        mrv [2], srv [2], mbo [2], sbo [2];

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  dpr_arb_ram u_dut (
    .clk(clk), .rst_n(rst_n),
    .l_en_n(en_n[0]), .l_wr_n(wr_n[0]), .l_oe_n(oe_n[0]), .l_addr(ad[0]), .l_wdata(wd[0]),
    .l_rdata(mrd[0]), .l_rvalid(mrv[0]), .l_busy_n(mbo[0]), .l_busy_in_n(mbi[0]),
    .r_en_n(en_n[1]), .r_wr_n(wr_n[1]), .r_oe_n(oe_n[1]), .r_addr(ad[1]), .r_wdata(wd[1]),
    .r_rdata(mrd[1]), .r_rvalid(mrv[1]), .r_busy_n(mbo[1]), .r_busy_in_n(mbi[1])
  );

  dpr_arb_ram #(.SLAVE(1'b1)) u_slv (
    .clk(clk), .rst_n(rst_n),
    .l_en_n(en_n[0]), .l_wr_n(wr_n[0]), .l_oe_n(oe_n[0]), .l_addr(ad[0]), .l_wdata(wd[0]),
    .l_rdata(srd[0]), .l_rvalid(srv[0]), .l_busy_n(sbo[0]), .l_busy_in_n(sbi[0]),
    .r_en_n(en_n[1]), .r_wr_n(wr_n[1]), .r_oe_n(oe_n[1]), .r_addr(ad[1]), .r_wdata(wd[1]),
    .r_rdata(srd[1]), .r_rvalid(srv[1]), .r_busy_n(sbo[1]), .r_busy_in_n(sbi[1])
  );

  // Behavioural reference model
  logic [7:0]  mm [2048];
  logic [7:0]  sm [2048];
  int          own;
  logic        pen [2], st [2], mblk [2], mw [2], sw [2];
  logic [10:0] pad [2];
  logic        mt;
  logic [7:0]  e_mrd [2], e_srd [2];
  logic        e_mrv [2], e_srv [2], e_mbo [2], e_sbo [2];

  always @(posedge clk) begin
    if (!rst_n) begin
      own = 0;
      for (int i = 0; i < 2; i++) begin
        pen[i] = 0; pad[i] = '0;
        e_mrd[i] = '0; e_mrv[i] = 0; e_mbo[i] = 1;
        e_srd[i] = '0; e_srv[i] = 0; e_sbo[i] = 1;
      end
    end else begin
      mt = !en_n[0] && !en_n[1] && (ad[0] == ad[1]);
      for (int i = 0; i < 2; i++) st[i] = !en_n[i] && pen[i] && (ad[i] == pad[i]);
      if (!mt) own = 0;
      else if (own == 0) own = (st[1] && !st[0]) ? 2 : 1;
      for (int i = 0; i < 2; i++) begin
        mblk[i] = mt && (own == ((i == 0) ? 2 : 1));
        mw[i] = !en_n[i] && !wr_n[i] && !mblk[i];
        sw[i] = !en_n[i] && !wr_n[i] && sbi[i];
      end
      for (int i = 0; i < 2; i++) begin
        if (!en_n[i] && wr_n[i] && !oe_n[i]) begin
          e_mrv[i] = 1; e_srv[i] = 1;
          e_mrd[i] = (mw[1-i] && ad[1-i] == ad[i]) ? wd[1-i] : mm[ad[i]];
          e_srd[i] = (sw[1-i] && ad[1-i] == ad[i]) ? wd[1-i] : sm[ad[i]];
        end else begin
          e_mrv[i] = 0; e_srv[i] = 0; e_mrd[i] = '0; e_srd[i] = '0;
        end
      end
      for (int i = 0; i < 2; i++) begin
        if (mw[i]) mm[ad[i]] = wd[i];
        if (sw[i]) sm[ad[i]] = wd[i];
        pen[i] = !en_n[i];
        pad[i] = ad[i];
        e_sbo[i] = 1;
      end
      e_mbo[0] = (own != 2);
      e_mbo[1] = (own != 1);
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // Every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < 2; i++) begin
        chk($sformatf("R2 master data p%0d", i), {mrv[i], mrd[i]}, {e_mrv[i], e_mrd[i]});
        chk($sformatf("R6 master busy p%0d", i), mbo[i], e_mbo[i]);
        chk($sformatf("R12 slave data p%0d", i), {srv[i], srd[i]}, {e_srv[i], e_srd[i]});
        chk($sformatf("R12 slave busy p%0d", i), sbo[i], e_sbo[i]);
      end
    end
  end

  task automatic drv(input int s, input logic e, input logic w, input logic o,
                     input logic [10:0] a, input logic [7:0] d);
    en_n[s] = e; wr_n[s] = w; oe_n[s] = o; ad[s] = a; wd[s] = d;
  endtask
  task automatic drv_idle(input int s);                                 drv(s, 1, 1, 1, '0, '0); endtask
  task automatic drv_wr(input int s, input logic [10:0] a, input logic [7:0] d); drv(s, 0, 0, 1, a, d); endtask
  task automatic drv_rd(input int s, input logic [10:0] a);             drv(s, 0, 1, 0, a, '0); endtask
  task automatic tick; @(posedge clk); @(negedge clk); endtask
  task automatic idle_both; drv_idle(0); drv_idle(1); tick(); endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    for (int i = 0; i < 2; i++) begin drv_idle(i); mbi[i] = 1; sbi[i] = 1; end
    repeat (3) tick();
    chk("R1 reset busy", {mbo[0], mbo[1], sbo[0], sbo[1]}, 4'hF);
    chk("R1 reset data", {mrv[0], mrd[0], mrv[1], mrd[1]}, '0);
    rst_n = 1;
    tick();
    chk("R1 first cycle busy", {mbo[0], mbo[1]}, 2'b11);

    // R2 basic write then read, both address extremes
    drv_wr(0, 11'h155, 8'hA5); tick();
    drv_idle(0); drv_rd(1, 11'h155); tick();
    chk("R2 right reads left write", {mrv[1], mrd[1]}, {1'b1, 8'hA5});
    drv_idle(1); drv_wr(1, 11'h7FF, 8'h3C); tick();
    drv_idle(1); drv_rd(0, 11'h7FF); tick();
    chk("R2 top address", {mrv[0], mrd[0]}, {1'b1, 8'h3C});
    drv_wr(0, 11'h000, 8'h5A); tick();
    drv_rd(0, 11'h000); tick();
    chk("R2 bottom address", {mrv[0], mrd[0]}, {1'b1, 8'h5A});

    // R3 idle port and inactive output enable
    drv(0, 1, 0, 1, 11'h155, 8'hFF); tick();
    chk("R3 disabled port data", {mrv[0], mrd[0]}, '0);
    drv(0, 0, 1, 1, 11'h155, 8'h00); tick();
    chk("R3 output enable high", {mrv[0], mrd[0]}, '0);
    drv_rd(0, 11'h155); tick();
    chk("R3 disabled write ignored", mrd[0], 8'hA5);

    // R4 no match cases
    drv_rd(0, 11'h155); drv_rd(1, 11'h154); tick();
    chk("R4 different addresses", {mbo[0], mbo[1]}, 2'b11);
    drv(1, 1, 1, 0, 11'h155, 8'h00); tick();
    chk("R4 one side disabled", {mbo[0], mbo[1]}, 2'b11);

    // R5 and R7: simultaneous reads of one location
    idle_both();
    drv_rd(0, 11'h155); drv_rd(1, 11'h155); tick();
    chk("R7 tie right busy", {mbo[0], mbo[1]}, 2'b10);
    chk("R5 both reads served", {mrd[0], mrd[1]}, {8'hA5, 8'hA5});
    chk("R8 not both low", mbo[0] | mbo[1], 1'b1);
    chk("R12 slave quiet on contention", {sbo[0], sbo[1]}, 2'b11);

    // R10 hold then release
    tick();
    chk("R10 winner held", mbo[1], 1'b0);
    drv_rd(1, 11'h7FF); tick();
    chk("R10 release after mismatch", {mbo[0], mbo[1]}, 2'b11);

    // R6 and R9: right arrives first, left write suppressed
    idle_both();
    drv_wr(0, 11'h020, 8'h11); tick();
    drv_idle(0); drv_rd(1, 11'h020); tick();
    drv_wr(0, 11'h020, 8'h99); tick();
    chk("R6 later left flagged", {mbo[0], mbo[1]}, 2'b01);
    chk("R9 winner sees old byte", mrd[1], 8'h11);
    drv_idle(1); drv_rd(0, 11'h020); tick();
    chk("R9 blocked write left memory", mrd[0], 8'h11);

    // R11 bypass: left wins tie while writing, right reads new byte
    idle_both();
    drv_wr(0, 11'h040, 8'h77); drv_rd(1, 11'h040); tick();
    chk("R11 bypass data", {mrv[1], mrd[1]}, {1'b1, 8'h77});
    chk("R7 tie right busy on write", mbo[1], 1'b0);

    // R12 and R13: busy inputs
    idle_both();
    drv_wr(0, 11'h060, 8'h05); drv_wr(1, 11'h061, 8'h01); tick();
    mbi[0] = 0; sbi[0] = 0;
    drv_wr(0, 11'h060, 8'h42); drv_wr(1, 11'h061, 8'h66); tick();
    chk("R12 slave outputs high", {sbo[0], sbo[1]}, 2'b11);
    drv_rd(0, 11'h060); drv_rd(1, 11'h061); tick();
    chk("R13 master ignores busy input", mrd[0], 8'h42);
    chk("R12 slave left write blocked", {srv[0], srd[0]}, {1'b1, 8'h05});
    chk("R12 slave right write done", srd[1], 8'h66);
    mbi[0] = 1; sbi[0] = 1;
    idle_both();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule